// File: doc/BRIEF.md
# Pulse Wave Sound Channel

This block produces a rectangle tone for a retro sound generator. A period divider clocked by the tone clock expires once every period+1 cycles, and each expiry advances an eight-step duty sequencer. The selected duty shape gates a 4-bit amplitude. That amplitude comes either from a fixed volume field or from a decaying envelope. A length timer, loaded through a coded lookup, silences the channel when it runs out.

A frequency sweep unit can rewrite the period while the tone plays, raising or lowering it by a shifted copy of itself. The envelope, length and sweep units advance only on single-cycle strobes from an external frame sequencer. Register fields arrive already decoded. A trigger strobe marks a write to the register that holds the high period bits and the duration.

Top module: `pulse_voice`

## Requirements
- R1: After reset the amplitude output is 0 and the length counter is 0, so the channel is silent.
- R2: The duty step (0 to 7, wrapping) advances once every period+1 tone clocks. It does not change between divider expiries.
- R3: The output is non-zero only while the duty step is below a threshold. The threshold is 1, 2, 4 or 6 for duty codes 0, 1, 2 and 3, giving 12.5%, 25%, 50% and 75%.
- R4: A trigger loads the length counter from the 5-bit duration code. If the code is odd, the length is 2*(code>>1)+2. If the code is even, the length is 10*((code>>1)+1).
- R5: The length counter decrements on each length strobe unless the loop bit is set. It stops at 0, and while it is 0 the amplitude output is 0.
- R6: When constant-volume mode is set, a non-zero output equals the volume field.
- R7: Otherwise the output equals the envelope level. The level decrements once every decay+1 envelope strobes, where the decay value is the volume field. At 0 it stays at 0 if loop is clear and wraps to 15 if loop is set.
- R8: While the sweep is enabled, the period is recomputed once every rate+1 sweep strobes. Mode 0 adds period>>shift. Mode 1 subtracts it.
- R9: The sweep leaves the period unchanged when the shift field is 0 or when the result would exceed 2047.
- R10: A trigger loads the period input into both the period and the divider, clears the duty step to 0, sets the envelope to 15 and reloads both the envelope and sweep dividers. A separate period-load strobe loads only the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tone clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_i | input | 11 | Period field |
| period_ld_i | input | 1 | Load period only |
| trig_i | input | 1 | Period-high/duration register write strobe |
| duty_i | input | 2 | Duty code |
| vol_i | input | 4 | Constant volume or envelope decay value |
| const_vol_i | input | 1 | 1 selects constant volume |
| loop_i | input | 1 | Envelope wrap and length hold |
| dur_code_i | input | 5 | Coded duration |
| sweep_en_i | input | 1 | Sweep enable |
| sweep_shift_i | input | 3 | Sweep shift amount |
| sweep_neg_i | input | 1 | Sweep mode, 1 subtracts |
| sweep_rate_i | input | 3 | Sweep divider reload |
| env_stb_i | input | 1 | Envelope strobe |
| len_stb_i | input | 1 | Length strobe |
| swp_stb_i | input | 1 | Sweep strobe |
| amp_o | output | 4 | Amplitude sample |

## Verification
The four duty codes are played at short periods with a fixed volume. This separates the threshold of each shape from the divider rate. The envelope runs with the loop bit clear and then set, which distinguishes holding at zero from wrapping to 15. Several duration codes, both odd and even, are run to silence, so each lookup branch shows up in the mute time. Sweeps run upward, downward, with shift zero and at the 11-bit limit, and each case shows up as a distinct change in step timing. The expected output is compared on every clock.

// File: rtl/pv_pkg.sv
package pv_pkg;
  localparam int PER_W  = 11;
  localparam int SH_W   = 3;
  localparam int RATE_W = 3;
  localparam int VOL_W  = 4;
  localparam int LEN_W  = 8;
  localparam int CODE_W = 5;
  localparam int STEP_W = 3;

  // duty shape: high while step is below the code's threshold
  function automatic logic duty_on(input logic [1:0] duty, input logic [STEP_W-1:0] step);
    logic [STEP_W:0] thr;
    case (duty)
      2'd0:    thr = 4'd1;
      2'd1:    thr = 4'd2;
      2'd2:    thr = 4'd4;
      default: thr = 4'd6;
    endcase
    return {1'b0, step} < thr;
  endfunction

  // duration code to length count
  function automatic logic [LEN_W-1:0] len_lookup(input logic [CODE_W-1:0] code);
    logic [LEN_W-1:0] half;
    half = {{(LEN_W-CODE_W+1){1'b0}}, code[CODE_W-1:1]};
    if (code[0]) return (half << 1) + LEN_W'(2);
    else         return (half + LEN_W'(1)) * LEN_W'(10);
  endfunction

  // sweep target, one extra bit to flag overflow
  function automatic logic [PER_W:0] sweep_next(input logic [PER_W-1:0] per,
                                                 input logic [SH_W-1:0] sh,
                                                 input logic neg);
    logic [PER_W:0] p, d;
    p = {1'b0, per};
    d = p >> sh;
    return neg ? (p - d) : (p + d);
  endfunction
endpackage

// File: rtl/pv_tone.sv
module pv_tone
  import pv_pkg::*;
#(
  parameter int PW = PER_W,
  parameter int SW = SH_W,
  parameter int RW = RATE_W,
  parameter int TW = STEP_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] period_i,
  input  logic          period_ld_i,
  input  logic          trig_i,
  input  logic          swp_stb_i,
  input  logic          swp_en_i,
  input  logic [SW-1:0] swp_shift_i,
  input  logic          swp_neg_i,
  input  logic [RW-1:0] swp_rate_i,
  output logic [TW-1:0] step_o
);
  logic [PW-1:0] per_q, cnt_q;
  logic [RW-1:0] swd_q;
  logic [PW:0]   target;
  logic          expire, sweep_fire;

  assign target     = sweep_next(per_q, swp_shift_i, swp_neg_i);
  assign expire     = (cnt_q == '0);
  assign sweep_fire = swp_stb_i && swp_en_i && (swd_q == '0) &&
                      (swp_shift_i != '0) && !target[PW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q  <= '0;
      cnt_q  <= '0;
      step_o <= '0;
      swd_q  <= '0;
    end else if (trig_i) begin
      per_q  <= period_i;
      cnt_q  <= period_i;
      step_o <= '0;
      swd_q  <= swp_rate_i;
    end else begin
      if (period_ld_i)     per_q <= period_i;
      else if (sweep_fire) per_q <= target[PW-1:0];
      if (expire) begin
        cnt_q  <= per_q;
        step_o <= step_o + 1'b1;
      end else begin
        cnt_q  <= cnt_q - 1'b1;
      end
      if (swp_stb_i && swp_en_i)
        swd_q <= (swd_q == '0) ? swp_rate_i : swd_q - 1'b1;
    end
  end

  p_step_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig_i && !expire) |=> $stable(step_o));
  p_step_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig_i && expire && step_o == '1) |=> (step_o == '0));
  p_trig_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    trig_i |=> (step_o == '0));
  p_noshift_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig_i && !period_ld_i && swp_shift_i == '0) |=> $stable(per_q));
  p_sweep_up_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sweep_fire && !swp_neg_i && !period_ld_i && !trig_i) |=> (per_q >= $past(per_q)));
  p_sweep_down_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sweep_fire && swp_neg_i && !period_ld_i && !trig_i) |=> (per_q <= $past(per_q)));
endmodule

// File: rtl/pv_len.sv
module pv_len
  import pv_pkg::*;
#(
  parameter int LW = LEN_W,
  parameter int CW = CODE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig_i,
  input  logic [CW-1:0] code_i,
  input  logic          stb_i,
  input  logic          hold_i,
  output logic          active_o
);
  logic [LW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               cnt_q <= '0;
    else if (trig_i)                          cnt_q <= len_lookup(code_i);
    else if (stb_i && !hold_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign active_o = (cnt_q != '0);

  p_len_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_i && hold_i && !trig_i) |=> $stable(cnt_q));
  p_len_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !trig_i) |=> (cnt_q == '0));
  p_len_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    trig_i |=> (cnt_q != '0));
endmodule

// File: rtl/pv_env.sv
module pv_env
  import pv_pkg::*;
#(
  parameter int VW = VOL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig_i,
  input  logic          stb_i,
  input  logic [VW-1:0] rate_i,
  input  logic          loop_i,
  output logic [VW-1:0] level_o
);
  logic [VW-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_o <= '0;
      div_q   <= '0;
    end else if (trig_i) begin
      level_o <= '1;
      div_q   <= rate_i;
    end else if (stb_i) begin
      if (div_q == '0) begin
        div_q <= rate_i;
        if (level_o != '0) level_o <= level_o - 1'b1;
        else if (loop_i)   level_o <= '1;
      end else begin
        div_q <= div_q - 1'b1;
      end
    end
  end

  p_env_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    trig_i |=> (level_o == '1));
  p_env_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (level_o == '0 && !loop_i && !trig_i) |=> (level_o == '0));
  p_env_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig_i && !stb_i) |=> $stable(level_o));
endmodule

// File: rtl/pulse_voice.sv
module pulse_voice
  import pv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PER_W-1:0]  period_i,
  input  logic              period_ld_i,
  input  logic              trig_i,
  input  logic [1:0]        duty_i,
  input  logic [VOL_W-1:0]  vol_i,
  input  logic              const_vol_i,
  input  logic              loop_i,
  input  logic [CODE_W-1:0] dur_code_i,
  input  logic              sweep_en_i,
  input  logic [SH_W-1:0]   sweep_shift_i,
  input  logic              sweep_neg_i,
  input  logic [RATE_W-1:0] sweep_rate_i,
  input  logic              env_stb_i,
  input  logic              len_stb_i,
  input  logic              swp_stb_i,
  output logic [VOL_W-1:0]  amp_o
);
  logic [STEP_W-1:0] step;
  logic              len_active;
  logic [VOL_W-1:0]  env_level;
  logic              wave_hi;

  pv_tone u_tone (
    .clk(clk), .rst_n(rst_n), .period_i(period_i), .period_ld_i(period_ld_i),
    .trig_i(trig_i), .swp_stb_i(swp_stb_i), .swp_en_i(sweep_en_i),
    .swp_shift_i(sweep_shift_i), .swp_neg_i(sweep_neg_i),
    .swp_rate_i(sweep_rate_i), .step_o(step)
  );

  pv_len u_len (
    .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .code_i(dur_code_i),
    .stb_i(len_stb_i), .hold_i(loop_i), .active_o(len_active)
  );

  pv_env u_env (
    .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .stb_i(env_stb_i),
    .rate_i(vol_i), .loop_i(loop_i), .level_o(env_level)
  );

  assign wave_hi = duty_on(duty_i, step);
  assign amp_o   = (len_active && wave_hi) ? (const_vol_i ? vol_i : env_level) : '0;

  p_mute_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !len_active |-> (amp_o == '0));
  p_const_vol_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (const_vol_i && amp_o != '0) |-> (amp_o == vol_i));
  p_env_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!const_vol_i && amp_o != '0) |-> (amp_o == env_level));
endmodule

// File: tb/tb_pulse_voice.sv
module tb_pulse_voice;
  logic clk = 0, rst_n = 0;
  logic [10:0] period = 0;
  logic per_ld = 0, trig = 0;
  logic [1:0] duty = 0;
  logic [3:0] vol = 0;
  logic cv = 0, loop_b = 0;
  logic [4:0] code = 0;
  logic swen = 0, swneg = 0;
  logic [2:0] swsh = 0, swrate = 0;
  logic estb = 0, lstb = 0, sstb = 0;
  logic [3:0] amp;

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;
  string cur_req = "R1";

  // reference state
  int m_per = 0, m_cnt = 0, m_step = 0, m_swd = 0, m_len = 0, m_env = 0, m_ediv = 0;

  always #10 clk = ~clk;

  pulse_voice dut (
    .clk(clk), .rst_n(rst_n), .period_i(period), .period_ld_i(per_ld), .trig_i(trig),
    .duty_i(duty), .vol_i(vol), .const_vol_i(cv), .loop_i(loop_b), .dur_code_i(code),
    .sweep_en_i(swen), .sweep_shift_i(swsh), .sweep_neg_i(swneg), .sweep_rate_i(swrate),
    .env_stb_i(estb), .len_stb_i(lstb), .swp_stb_i(sstb), .amp_o(amp)
  );

  function automatic int ref_len(int c);
    int h = c / 2;
    if (c % 2 == 1) return 2 * h + 2;
    return 10 * (h + 1);
  endfunction

  function automatic int ref_amp();
    int thr;
    thr = (duty == 0) ? 1 : (duty == 1) ? 2 : (duty == 2) ? 4 : 6;
    if (m_len == 0 || m_step >= thr) return 0;
    return cv ? int'(vol) : m_env;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_per = 0; m_cnt = 0; m_step = 0; m_swd = 0; m_len = 0; m_env = 0; m_ediv = 0;
    end else begin
      // tone and sweep
      if (trig) begin
        m_per = period; m_cnt = period; m_step = 0; m_swd = swrate;
      end else begin
        int old_per, tgt;
        bit fire;
        old_per = m_per;
        tgt = swneg ? old_per - (old_per >> swsh) : old_per + (old_per >> swsh);
        fire = sstb && swen && m_swd == 0 && swsh != 0 && tgt < 2048;
        if (per_ld) m_per = period;
        else if (fire) m_per = tgt;
        if (m_cnt == 0) begin m_cnt = old_per; m_step = (m_step + 1) % 8; end
        else m_cnt = m_cnt - 1;
        if (sstb && swen) m_swd = (m_swd == 0) ? int'(swrate) : m_swd - 1;
      end
      // length
      if (trig) m_len = ref_len(code);
      else if (lstb && !loop_b && m_len > 0) m_len = m_len - 1;
      // envelope
      if (trig) begin m_env = 15; m_ediv = vol; end
      else if (estb) begin
        if (m_ediv == 0) begin
          m_ediv = vol;
          if (m_env > 0) m_env = m_env - 1;
          else if (loop_b) m_env = 15;
        end else m_ediv = m_ediv - 1;
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      int exp_a;
      exp_a = ref_amp();
      total++;
      if (int'(amp) != exp_a) begin
        bad++;
        $display("FAIL %s cycle %0d: amp=%0d expected=%0d", cur_req, cyc, amp, exp_a);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      bad++;
      $display("FAIL watchdog: cycles=%0d expected below 150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic run(int n, int ek, int lk, int sk);
    for (int i = 1; i <= n; i++) begin
      @(posedge clk); #2;
      estb = (ek > 0) && (i % ek == 0);
      lstb = (lk > 0) && (i % lk == 0);
      sstb = (sk > 0) && (i % sk == 0);
    end
    @(posedge clk); #2;
    estb = 0; lstb = 0; sstb = 0;
  endtask

  task automatic fire_trig();
    @(posedge clk); #2; trig = 1;
    @(posedge clk); #2; trig = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(negedge clk);
    total++;  // R1 reset state
    if (amp !== 4'd0) begin
      bad++;
      $display("FAIL R1: amp=%0d expected=0", amp);
    end

    // R3 / R2: duty shapes at short periods, fixed volume, held length
    cur_req = "R3";
    cv = 1; vol = 9; loop_b = 1; code = 31;
    for (int d = 0; d < 4; d++) begin
      duty = d[1:0]; period = 11'(d + 1);
      fire_trig();
      run(90, 0, 0, 0);
    end
    cur_req = "R2";
    period = 6; duty = 2;
    fire_trig();
    run(120, 0, 0, 0);

    // R6: constant volume follows field
    cur_req = "R6";
    duty = 3; period = 0;
    fire_trig();
    for (int v = 0; v < 16; v += 5) begin
      vol = v[3:0];
      run(12, 0, 0, 0);
    end

    // R7: envelope decay holding, then wrapping
    cur_req = "R7";
    cv = 0; vol = 1; loop_b = 0; duty = 3; period = 0; code = 31;
    fire_trig();
    run(130, 3, 0, 0);
    loop_b = 1;
    fire_trig();
    run(130, 2, 0, 0);

    // R5: length counts down and mutes; loop holds it
    cur_req = "R5";
    cv = 1; vol = 7; loop_b = 0; code = 1;
    fire_trig();
    run(60, 0, 10, 0);
    loop_b = 1; code = 3;
    fire_trig();
    run(60, 0, 5, 0);

    // R4: lookup values seen as mute times
    cur_req = "R4";
    loop_b = 0;
    for (int k = 0; k < 4; k++) begin
      code = (k == 0) ? 5'd0 : (k == 1) ? 5'd3 : (k == 2) ? 5'd31 : 5'd14;
      fire_trig();
      run(2 * ref_len(code) + 10, 0, 2, 0);
    end

    // R8: sweep up then down
    cur_req = "R8";
    loop_b = 1; code = 31; duty = 2;
    swen = 1; swsh = 1; swneg = 0; swrate = 1; period = 20;
    fire_trig();
    run(500, 0, 0, 15);
    swneg = 1; swsh = 2; swrate = 0; period = 300;
    fire_trig();
    run(600, 0, 0, 20);

    // R9: zero shift and overflow leave the period alone
    cur_req = "R9";
    swneg = 0; swsh = 0; period = 10;
    fire_trig();
    run(200, 0, 0, 4);
    swsh = 1; period = 1500;
    fire_trig();
    run(3500, 0, 0, 3);

    // R10: trigger restarts sequence, period-load changes only the period
    cur_req = "R10";
    swen = 0; period = 5; duty = 0;
    fire_trig();
    run(23, 0, 0, 0);
    fire_trig();
    run(10, 0, 0, 0);
    period = 2;
    @(posedge clk); #2 per_ld = 1;
    @(posedge clk); #2 per_ld = 0;
    run(40, 0, 0, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule